// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block sits beside a DDR SDRAM command path. It keeps a copy of the device's base mode register by watching load-mode commands on the bank-select and address buses. From that copy it decodes the burst length, the burst type, the CAS read latency and the operating mode. When a read or write request arrives with a starting column, it issues the column address of every data beat, one per clock, in the order the device uses for that burst. It also flags the first and the last beat of each burst.

The block also reports the effective read latency in half-clock units. When the registered-module input is set, one extra clock is added to that figure. A flag shows when any decoded field holds a reserved code. A request made while the burst length is reserved is answered with an error pulse and produces no beats. DRAM timing, data capture, refresh and bank tracking belong to other blocks.

Top module: `burst_col_seq`

## Requirements
- R1: A load-mode command (`lmr_valid` high at a clock edge) updates the stored settings only when `lmr_ba` is 2'b00. Any other bank-select value leaves the burst settings, the latency and the flags unchanged.
- R2: Bits 2:0 of `lmr_addr` select the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 and 3'b011 gives 8. A burst issues exactly that many beats, with `beat_first` on the first beat only and `beat_last` on the last beat only.
- R3: When bit 3 of `lmr_addr` is 0 (sequential), the beat offsets count up from the start column and wrap inside the aligned block of burst length. Only bit 0 (2 beats), bits 1:0 (4 beats) or bits 2:0 (8 beats) change; every other column bit stays equal to the start column.
- R4: When bit 3 of `lmr_addr` is 1 (interleaved), the low burst bits of beat i equal the start column's low burst bits XOR i. For example, an 8-beat burst starting at offset 3 gives 3,2,1,0,7,6,5,4.
- R5: Bits 6:4 of `lmr_addr` hold the latency code. Code 3'b010 reports `rd_lat_half` = 4 and code 3'b110 reports 5. Any other code reports 0 and raises `cfg_reserved`.
- R6: While `reg_mode` is high and the latency code is valid, `rd_lat_half` is 2 higher than the value given in R5. This is combinational from `reg_mode`.
- R7: Bits 12:7 of `lmr_addr` hold the operating mode. 6'b000000 is normal operation. 6'b000010 (only address bit 8 set) is normal operation and also pulses `dll_reset` for the one cycle after the load. Any other value raises `cfg_reserved`.
- R8: A burst-length code that is not listed in R2 raises `cfg_reserved`. A request accepted under such a code gives a one-cycle `req_err` pulse in the next cycle and issues no beats.
- R9: `req_ready` is high when the block is idle. A request is taken at an edge where `req_valid` and `req_ready` are both high. The first beat appears in the next cycle, and one beat follows per cycle after that. `req_ready` stays low through the last beat and returns high in the cycle after it.
- R10: Burst length and type are sampled when a request is accepted. A load-mode command during a burst affects only later bursts.
- R11: After reset, `req_ready` is 1 and `beat_valid`, `req_err` and `dll_reset` are 0. The stored settings are 2 beats, sequential, latency code 3'b010 and normal mode, so `rd_lat_half` is 4 with `reg_mode` low and `cfg_reserved` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lmr_valid | input | 1 | A load-mode command is present this cycle |
| lmr_ba | input | 2 | Bank-select bits of the load-mode command |
| lmr_addr | input | 13 | Address bus of the load-mode command |
| reg_mode | input | 1 | Registered-module mode; adds one clock of read latency |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Block is idle and can take a request |
| req_col | input | COL_W | Starting column of the request |
| beat_valid | output | 1 | A beat address is issued this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_first | output | 1 | Current beat is the first of its burst |
| beat_last | output | 1 | Current beat is the last of its burst |
| req_err | output | 1 | One-cycle pulse: request rejected because the burst length is reserved |
| rd_lat_half | output | LAT_W | Effective read latency in half clocks, 0 if the latency code is reserved |
| cfg_reserved | output | 1 | A stored field holds a reserved code |
| dll_reset | output | 1 | One-cycle pulse after a load that requests a DLL reset |

## Verification
A load-mode command is captured at one edge. The decoded latency, the reserved flag and the DLL pulse can be read in the half cycle that follows, and the DLL pulse has cleared one cycle later. `reg_mode` acts on `rd_lat_half` within the same cycle. After an accepting edge, beat i is sampled on the falling edge that lies i cycles later. A rejected request shows `req_err` on the first falling edge after acceptance. The bench drives every input on a falling edge and reads every result on a later falling edge, so each check lands exactly on the cycle the requirement names. It also checks the idle cycle after the last beat.

// File: rtl/burst_seq_pkg.sv
// Package: shared types and field decoders for the burst column sequencer.
// Assumes a 13-bit mode-register image whose bit order matches the address bus.
package burst_seq_pkg;

    localparam int OFF_W = 3;   // widest burst (8 beats) spans 3 column bits

    typedef enum logic {
        BT_SEQ = 1'b0,
        BT_INT = 1'b1
    } burst_type_e;

    // Field layout follows the address bus: [12:7] mode, [6:4] latency, [3] type, [2:0] length
    typedef struct packed {
        logic [5:0]  op_code;
        logic [2:0]  cl_code;
        burst_type_e bt;
        logic [2:0]  bl_code;
    } mode_fields_t;

    localparam mode_fields_t MODE_RESET = '{
        op_code: 6'b000000,
        cl_code: 3'b010,
        bt:      BT_SEQ,
        bl_code: 3'b001
    };

    localparam logic [5:0] OP_NORMAL  = 6'b000000;
    localparam logic [5:0] OP_DLL_RST = 6'b000010;

    // Low-bit mask of the burst block; zero marks a reserved length code
    function automatic logic [OFF_W-1:0] bl_mask(input logic [2:0] code);
        case (code)
            3'b001:  return 3'b001;
            3'b010:  return 3'b011;
            3'b011:  return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    // CAS latency in half clocks; zero marks a reserved latency code
    function automatic logic [2:0] cl_half(input logic [2:0] code);
        case (code)
            3'b010:  return 3'd4;
            3'b110:  return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/mode_reg_dec.sv
// mode_reg_dec: holds the base mode register and decodes its fields.
// Assumes load-mode commands are single-cycle strobes; only bank select 0 targets this register.
module mode_reg_dec
    import burst_seq_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int LAT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lmr_valid,
    input  logic [BA_W-1:0]     lmr_ba,
    input  logic [12:0]         lmr_addr,
    input  logic                reg_mode,
    output mode_fields_t        mode_q,
    output logic [OFF_W-1:0]    len_mask,
    output logic                bl_rsv,
    output logic [LAT_W-1:0]    rd_lat_half,
    output logic                cfg_reserved,
    output logic                dll_reset
);

    mode_fields_t     load_val;
    logic             base_load;
    logic [2:0]       lat_base;
    logic             cl_rsv;
    logic             op_rsv;

    assign load_val  = mode_fields_t'(lmr_addr);
    assign base_load = lmr_valid && (lmr_ba == '0);

    // Capture the register image and the one-cycle DLL reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RESET;
            dll_reset <= 1'b0;
        end else begin
            dll_reset <= base_load && (load_val.op_code == OP_DLL_RST);
            if (base_load) begin
                mode_q <= load_val;
            end
        end
    end

    // Decode the stored fields into length mask, latency and reserved flags
    always_comb begin
        len_mask     = bl_mask(mode_q.bl_code);
        bl_rsv       = (len_mask == '0);
        lat_base     = cl_half(mode_q.cl_code);
        cl_rsv       = (lat_base == 3'd0);
        op_rsv       = (mode_q.op_code != OP_NORMAL) && (mode_q.op_code != OP_DLL_RST);
        cfg_reserved = bl_rsv || cl_rsv || op_rsv;
        if (cl_rsv) begin
            rd_lat_half = '0;
        end else begin
            rd_lat_half = LAT_W'(lat_base) + (reg_mode ? LAT_W'(2) : LAT_W'(0));
        end
    end

endmodule

// File: rtl/beat_order_gen.sv
// beat_order_gen: accepts a burst request and issues one column address per clock.
// Assumes len_mask is 1, 3 or 7 when bl_rsv is low; length and type are frozen at acceptance.
module beat_order_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [COL_W-1:0]    req_col,
    input  logic [OFF_W-1:0]    len_mask,
    input  burst_type_e         bt_cfg,
    input  logic                bl_rsv,
    output logic                req_ready,
    output logic                beat_valid,
    output logic [COL_W-1:0]    beat_col,
    output logic                beat_first,
    output logic                beat_last,
    output logic                req_err
);

    logic               busy;
    logic [OFF_W-1:0]   idx;
    logic [OFF_W-1:0]   mask_q;
    burst_type_e        bt_q;
    logic [COL_W-1:0]   start_q;
    logic               accept;
    logic [OFF_W-1:0]   off_seq;
    logic [OFF_W-1:0]   off_int;
    logic [OFF_W-1:0]   off_sel;
    logic [OFF_W-1:0]   start_lo;

    assign accept    = req_valid && !busy;
    assign req_ready = !busy;

    // Burst state: latch the request, step the beat index, flag rejections
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            mask_q  <= '0;
            bt_q    <= BT_SEQ;
            start_q <= '0;
            req_err <= 1'b0;
        end else begin
            req_err <= accept && bl_rsv;
            if (accept && !bl_rsv) begin
                busy    <= 1'b1;
                idx     <= '0;
                mask_q  <= len_mask;
                bt_q    <= bt_cfg;
                start_q <= req_col;
            end else if (busy) begin
                if (idx == mask_q) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Form the beat address: sequential wrap or interleaved XOR inside the burst block
    always_comb begin
        start_lo   = start_q[OFF_W-1:0];
        off_seq    = start_lo + idx;
        off_int    = start_lo ^ idx;
        off_sel    = (bt_q == BT_INT) ? off_int : off_seq;
        beat_col   = {start_q[COL_W-1:OFF_W], (start_lo & ~mask_q) | (off_sel & mask_q)};
        beat_valid = busy;
        beat_first = busy && (idx == '0);
        beat_last  = busy && (idx == mask_q);
    end

endmodule

// File: rtl/burst_col_seq.sv
// burst_col_seq: top of the DDR burst column sequencer.
// Tracks the base mode register and orders column addresses of each burst.
// Assumes COL_W is larger than the 3 bits that an 8-beat burst spans.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int LAT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lmr_valid,
    input  logic [1:0]          lmr_ba,
    input  logic [12:0]         lmr_addr,
    input  logic                reg_mode,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [COL_W-1:0]    req_col,
    output logic                beat_valid,
    output logic [COL_W-1:0]    beat_col,
    output logic                beat_first,
    output logic                beat_last,
    output logic                req_err,
    output logic [LAT_W-1:0]    rd_lat_half,
    output logic                cfg_reserved,
    output logic                dll_reset
);

    mode_fields_t       mode_q;
    logic [OFF_W-1:0]   len_mask;
    logic               bl_rsv;

    mode_reg_dec #(
        .BA_W  (2),
        .LAT_W (LAT_W)
    ) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .lmr_valid    (lmr_valid),
        .lmr_ba       (lmr_ba),
        .lmr_addr     (lmr_addr),
        .reg_mode     (reg_mode),
        .mode_q       (mode_q),
        .len_mask     (len_mask),
        .bl_rsv       (bl_rsv),
        .rd_lat_half  (rd_lat_half),
        .cfg_reserved (cfg_reserved),
        .dll_reset    (dll_reset)
    );

    beat_order_gen #(
        .COL_W (COL_W)
    ) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_col    (req_col),
        .len_mask   (len_mask),
        .bt_cfg     (mode_q.bt),
        .bl_rsv     (bl_rsv),
        .req_ready  (req_ready),
        .beat_valid (beat_valid),
        .beat_col   (beat_col),
        .beat_first (beat_first),
        .beat_last  (beat_last),
        .req_err    (req_err)
    );

endmodule

// File: rtl/burst_col_seq_chk.sv
// burst_col_seq_chk: protocol and ordering properties of burst_col_seq, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled while reset is low.
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lmr_valid,
    input logic [1:0]       lmr_ba,
    input logic [12:0]      mode_img,
    input logic             req_valid,
    input logic             req_ready,
    input logic             beat_valid,
    input logic [COL_W-1:0] beat_col,
    input logic             beat_first,
    input logic             beat_last,
    input logic             req_err,
    input logic             bl_rsv
);

    // Other bank selects leave the stored register untouched
    assert_other_bank_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr_valid && lmr_ba != 2'b00) |=> $stable(mode_img));

    // Flags only appear on valid beats, and the last beat ends the burst
    assert_first_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_first |-> beat_valid);
    assert_last_ends_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last) |=> !beat_valid);

    // Column bits above the burst block never move within a burst
    assert_upper_bits_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (beat_valid && $stable(beat_col[COL_W-1:3])));

    // A reserved length gives an error pulse and no beat
    assert_reject_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && bl_rsv) |=> (req_err && !beat_valid));
    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err);

    // Acceptance opens a burst next cycle; ready stays low during beats
    assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !bl_rsv) |=> (beat_valid && beat_first));
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lmr_valid  (lmr_valid),
    .lmr_ba     (lmr_ba),
    .mode_img   (mode_q),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .beat_valid (beat_valid),
    .beat_col   (beat_col),
    .beat_first (beat_first),
    .beat_last  (beat_last),
    .req_err    (req_err),
    .bl_rsv     (bl_rsv)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

    localparam int COL_W = 10;
    localparam int LAT_W = 4;
    localparam int NVEC  = 8;

    // Vector table: length code, type, start column, beat count, expected low offsets (nibble i = beat i)
    localparam logic [2:0]  V_BL  [NVEC] = '{3'b001, 3'b010, 3'b010, 3'b011, 3'b011, 3'b010, 3'b001, 3'b011};
    localparam logic        V_BT  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [9:0]  V_ST  [NVEC] = '{10'h1A1, 10'h1A1, 10'h1A2, 10'h1A3, 10'h1A5, 10'h1A7, 10'h1A6, 10'h1A0};
    localparam int          V_N   [NVEC] = '{2, 4, 4, 8, 8, 4, 2, 8};
    localparam logic [31:0] V_EXP [NVEC] = '{32'h00000001, 32'h00000321, 32'h00001032, 32'h45670123,
                                             32'h43210765, 32'h00004567, 32'h00000076, 32'h76543210};

    logic               clk = 1'b0;
    logic               rst_n;
    logic               lmr_valid;
    logic [1:0]         lmr_ba;
    logic [12:0]        lmr_addr;
    logic               reg_mode;
    logic               req_valid;
    logic               req_ready;
    logic [COL_W-1:0]   req_col;
    logic               beat_valid;
    logic [COL_W-1:0]   beat_col;
    logic               beat_first;
    logic               beat_last;
    logic               req_err;
    logic [LAT_W-1:0]   rd_lat_half;
    logic               cfg_reserved;
    logic               dll_reset;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .LAT_W(LAT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lmr_valid    (lmr_valid),
        .lmr_ba       (lmr_ba),
        .lmr_addr     (lmr_addr),
        .reg_mode     (reg_mode),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_col      (req_col),
        .beat_valid   (beat_valid),
        .beat_col     (beat_col),
        .beat_first   (beat_first),
        .beat_last    (beat_last),
        .req_err      (req_err),
        .rd_lat_half  (rd_lat_half),
        .cfg_reserved (cfg_reserved),
        .dll_reset    (dll_reset)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] mode_word(input logic [5:0] op, input logic [2:0] cl,
                                              input logic bt, input logic [2:0] bl);
        return {op, cl, bt, bl};
    endfunction

    // Drive one load-mode command; returns at the falling edge after its capture
    task automatic load_mode(input logic [1:0] ba, input logic [12:0] a);
        @(negedge clk);
        lmr_valid = 1'b1;
        lmr_ba    = ba;
        lmr_addr  = a;
        @(negedge clk);
        lmr_valid = 1'b0;
        lmr_ba    = 2'b00;
    endtask

    // Request a burst and check every beat; optionally load a new mode during beat 0
    task automatic run_burst(input logic [9:0] st, input int n, input logic [31:0] ex,
                             input bit mid, input logic [12:0] mid_addr, input string tag);
        @(negedge clk);
        chk({tag, " R9 ready idle"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_col   = st;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk({tag, " R9 beat valid"}, 32'(beat_valid), 32'd1);
            chk({tag, " R3 R4 beat col"}, 32'(beat_col), 32'((st & ~10'h7) | 10'(ex[4*i +: 3])));
            chk({tag, " R2 first flag"}, 32'(beat_first), 32'(i == 0));
            chk({tag, " R2 last flag"}, 32'(beat_last), 32'(i == n - 1));
            chk({tag, " R9 ready busy"}, 32'(req_ready), 32'd0);
            if (mid && i == 0) begin
                lmr_valid = 1'b1;
                lmr_ba    = 2'b00;
                lmr_addr  = mid_addr;
            end
            if (mid && i == 1) begin
                lmr_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk({tag, " R2 no extra beat"}, 32'(beat_valid), 32'd0);
        chk({tag, " R9 ready after"}, 32'(req_ready), 32'd1);
    endtask

    initial begin
        rst_n     = 1'b0;
        lmr_valid = 1'b0;
        lmr_ba    = 2'b00;
        lmr_addr  = '0;
        reg_mode  = 1'b0;
        req_valid = 1'b0;
        req_col   = '0;
        repeat (3) @(negedge clk);

        // R11: reset state
        chk("R11 ready", 32'(req_ready), 32'd1);
        chk("R11 beat_valid", 32'(beat_valid), 32'd0);
        chk("R11 req_err", 32'(req_err), 32'd0);
        chk("R11 dll_reset", 32'(dll_reset), 32'd0);
        chk("R11 latency", 32'(rd_lat_half), 32'd4);
        chk("R11 reserved", 32'(cfg_reserved), 32'd0);
        rst_n = 1'b1;
        run_burst(10'h0F3, 2, 32'h00000023, 1'b0, '0, "R11 default 2-beat seq");

        // Vector table: R2, R3, R4 under several lengths, types and starts
        for (int v = 0; v < NVEC; v++) begin
            load_mode(2'b00, mode_word(6'b000000, 3'b010, V_BT[v], V_BL[v]));
            chk("R2 valid length not reserved", 32'(cfg_reserved), 32'd0);
            run_burst(V_ST[v], V_N[v], V_EXP[v], 1'b0, '0, "R2 vector");
        end

        // R1: other bank select leaves 8-beat sequential and latency intact
        load_mode(2'b01, mode_word(6'b000000, 3'b110, 1'b1, 3'b001));
        chk("R1 latency unchanged", 32'(rd_lat_half), 32'd4);
        load_mode(2'b10, mode_word(6'b000010, 3'b011, 1'b1, 3'b000));
        chk("R1 no dll pulse", 32'(dll_reset), 32'd0);
        chk("R1 reserved unchanged", 32'(cfg_reserved), 32'd0);
        run_burst(10'h2C3, 8, 32'h21076543, 1'b0, '0, "R1 settings kept");

        // R5, R6: latency codes and registered mode
        load_mode(2'b00, mode_word(6'b000000, 3'b110, 1'b0, 3'b010));
        chk("R5 code 110", 32'(rd_lat_half), 32'd5);
        reg_mode = 1'b1;
        @(negedge clk);
        chk("R6 code 110 registered", 32'(rd_lat_half), 32'd7);
        load_mode(2'b00, mode_word(6'b000000, 3'b010, 1'b0, 3'b010));
        chk("R6 code 010 registered", 32'(rd_lat_half), 32'd6);
        load_mode(2'b00, mode_word(6'b000000, 3'b011, 1'b0, 3'b010));
        chk("R5 reserved latency value", 32'(rd_lat_half), 32'd0);
        chk("R5 reserved latency flag", 32'(cfg_reserved), 32'd1);
        reg_mode = 1'b0;

        // R7: DLL reset pulse and reserved operating modes
        load_mode(2'b00, mode_word(6'b000010, 3'b010, 1'b0, 3'b010));
        chk("R7 dll pulse", 32'(dll_reset), 32'd1);
        chk("R7 dll mode not reserved", 32'(cfg_reserved), 32'd0);
        @(negedge clk);
        chk("R7 dll pulse ends", 32'(dll_reset), 32'd0);
        load_mode(2'b00, mode_word(6'b000001, 3'b010, 1'b0, 3'b010));
        chk("R7 reserved mode flag", 32'(cfg_reserved), 32'd1);
        chk("R7 no pulse reserved", 32'(dll_reset), 32'd0);

        // R8: reserved length codes reject requests
        for (int k = 0; k < 2; k++) begin
            load_mode(2'b00, mode_word(6'b000000, 3'b010, 1'b0, (k == 0) ? 3'b111 : 3'b000));
            chk("R8 reserved length flag", 32'(cfg_reserved), 32'd1);
            req_valid = 1'b1;
            req_col   = 10'h055;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8 error pulse", 32'(req_err), 32'd1);
            chk("R8 no beat", 32'(beat_valid), 32'd0);
            @(negedge clk);
            chk("R8 error one cycle", 32'(req_err), 32'd0);
            chk("R8 still no beat", 32'(beat_valid), 32'd0);
            chk("R8 ready again", 32'(req_ready), 32'd1);
        end

        // R10: load during a burst affects only the next burst
        load_mode(2'b00, mode_word(6'b000000, 3'b010, 1'b0, 3'b010));
        run_burst(10'h155, 4, 32'h00004765, 1'b1, mode_word(6'b000000, 3'b010, 1'b1, 3'b011),
                  "R10 old settings kept");
        run_burst(10'h155, 8, 32'h23016745, 1'b0, '0, "R10 new settings used");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule